// File: doc/BRIEF.md
# Scoreboard Instruction Scheduler

This block schedules a short stream of decoded instructions across four functional units: one integer unit shared by ALU and load/store work, an FP adder, an FP multiplier and an FP divider. Instructions arrive in program order on a valid/ready input. The block does no arithmetic. It tracks only when each instruction may pass through its four stages (issue, operand read, execution complete, result write). Every eligible step happens on its own, in the first cycle the hazard rules allow. A unit status table and a 64-entry register result table carry the dependences. The register table covers R0–R31 and F0–F31.

Each instruction has a 3-bit class and three 6-bit register identifiers. Bit 5 of an identifier set means an FP register, so Rn is n and Fn is 32+n. The class codes are 0 integer ALU, 1 load, 2 store, 3 FP add/sub, 4 FP multiply and 5 FP divide. A load uses `in_dst` and base `in_src1`. A store uses base `in_src1` and data `in_src2`. Classes 6 and 7 are treated like class 0.

Input back-pressure works as follows. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_valid` and the fields must hold steady until that edge.

Each write produces one timing record on the output lane of that unit. The record holds the issue tag and the cycle stamp of each stage. The output is valid/ready with one shared `rec_ready`. While any lane holds a valid record and `rec_ready` is low, the whole scheduler freezes: no stage moves, `in_ready` is low and the cycle count stays put. `clr` starts a new run.

Top module: `sb_sched`

## Requirements
- R1: Instructions issue one at a time in program order. An instruction stalls (`in_ready` low) while its unit is busy. Class 0, 1 and 2 share unit 0 (lane 0). Class 3 is unit 1, class 4 is unit 2 and class 5 is unit 3. A unit freed by a write in cycle t can take a new instruction in cycle t+1 at the earliest.
- R2: An instruction that writes a register stalls at issue while the register result table shows a pending writer for that register (WAW). It may issue in the cycle after that writer's result write.
- R3: Operand read happens in the first cycle, later than the issue cycle, in which both needed sources have no pending producer. A source released by a write in cycle t is read in cycle t+1 at the earliest.
- R4: Execution completes exactly L cycles after the read cycle. L is the latency of the class: select 0 for load/store, 1 for integer ALU, 2 for FP add, 3 for FP multiply and 4 for FP divide.
- R5: The result write happens in a cycle later than execution complete. It waits while any other unit still has to read the destination register as a source that was marked ready (WAR). It proceeds in the cycle after that reader's operand read.
- R6: A store claims no register result entry and is never held by WAW, so a later writer of the register named in its `in_dst` issues freely. A load ignores `in_src2`, both for operand readiness and for WAR checks.
- R7: After reset the latencies are 1, 1, 2, 10 and 40 for selects 0 to 4. A `cfg_we` pulse sets one latency. It is ignored if the value lies outside 1–100, if the select is above 4, or while a run is active (first issue after `clr` until `done`).
- R8: Each result write yields one record on the lane of its unit, with the issue tag (0, 1, 2… counted from `clr`) and four cycle stamps. A record that is not taken holds the scheduler frozen and keeps its values. Stamps do not count frozen cycles.
- R9: Reset and `clr` empty both tables, drop records, zero the tag count and make the current cycle number 1. Latency settings are kept. After reset `in_ready` is 1, no record is valid and `done` is 0.
- R10: `done` rises in the cycle after the last unit goes idle, once an instruction flagged `in_last` has issued. It stays high until `clr`.
- R11: If an instruction issues in the cycle in which the producer of one of its sources writes, that source counts as ready. The instruction reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous run restart |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted on this edge if valid |
| in_op | input | 3 | Operation class |
| in_dst | input | 6 | Destination register id |
| in_src1 | input | 6 | First source (base for memory) |
| in_src2 | input | 6 | Second source (store data) |
| in_last | input | 1 | Marks the final instruction of the run |
| cfg_we | input | 1 | Latency write strobe |
| cfg_sel | input | 3 | Latency select |
| cfg_val | input | LATW | Latency value |
| rec_valid | output | 4 | Per-unit record valid |
| rec_ready | input | 1 | Records taken |
| rec_tag | output | 4*TAGW | Per-unit issue tag |
| rec_iss | output | 4*CW | Per-unit issue cycle |
| rec_rd | output | 4*CW | Per-unit operand read cycle |
| rec_ex | output | 4*CW | Per-unit execution complete cycle |
| rec_wr | output | 4*CW | Per-unit result write cycle |
| done | output | 1 | All instructions written |

## Verification
Two pairs of functions can fall in one cycle. In the first pair, an issue coincides with the result write of the unit producing one of its sources. A store whose data register is being written is made to issue on exactly that write cycle. The check is that it reads one cycle later instead of waiting forever. In the second pair, a register write coincides with a reader still in its operand-read stage. A long divide that reads a register later overwritten by a short add holds the add at write-back until the cycle after the divide's read. In both cases the timing records are compared with stamps worked out by hand.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NFU  = 4;
  localparam int UW   = 2;
  localparam int RW   = 6;
  localparam int NREG = 1 << RW;
  localparam int NCLS = 5;

  typedef enum logic [2:0] {
    OP_ALU  = 3'd0,
    OP_LD   = 3'd1,
    OP_SD   = 3'd2,
    OP_FADD = 3'd3,
    OP_FMUL = 3'd4,
    OP_FDIV = 3'd5
  } op_e;

  function automatic logic [UW-1:0] unit_of(input logic [2:0] op);
    case (op)
      3'd3:    return 2'd1;
      3'd4:    return 2'd2;
      3'd5:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] lat_cls_of(input logic [2:0] op);
    case (op)
      3'd1, 3'd2: return 3'd0;
      3'd3:       return 3'd2;
      3'd4:       return 3'd3;
      3'd5:       return 3'd4;
      default:    return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sb_lat_cfg.sv
module sb_lat_cfg #(
  parameter int LATW    = 7,
  parameter int LAT_MAX = 100
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            lock,
  input  logic                            cfg_we,
  input  logic [2:0]                      cfg_sel,
  input  logic [LATW-1:0]                 cfg_val,
  output logic [sb_pkg::NCLS*LATW-1:0]    lat_flat
);
  import sb_pkg::*;

  function automatic logic [LATW-1:0] boot_lat(input int i);
    case (i)
      2:       return LATW'(2);
      3:       return LATW'(10);
      4:       return LATW'(40);
      default: return LATW'(1);
    endcase
  endfunction

  logic [LATW-1:0] lat_q [NCLS];
  logic            wr_ok;

  assign wr_ok = cfg_we && !lock && (cfg_val != '0) &&
                 (cfg_val <= LATW'(LAT_MAX)) && (int'(cfg_sel) < NCLS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCLS; i++) lat_q[i] <= boot_lat(i);
    end else if (wr_ok) begin
      lat_q[cfg_sel] <= cfg_val;
    end
  end

  for (genvar i = 0; i < NCLS; i++) begin : g_flat
    assign lat_flat[i*LATW +: LATW] = lat_q[i];
  end

  AST_LAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(lat_flat)) else $error("latency changed during run"); // R7
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          set_en,
  input  logic [sb_pkg::RW-1:0]         set_idx,
  input  logic [sb_pkg::UW-1:0]         set_unit,
  input  logic [sb_pkg::NFU-1:0]        rel_en,
  input  logic [sb_pkg::NFU*sb_pkg::RW-1:0] rel_idx,
  input  logic [sb_pkg::RW-1:0]         look_a,
  input  logic [sb_pkg::RW-1:0]         look_b,
  input  logic [sb_pkg::RW-1:0]         look_c,
  output logic                          pend_a,
  output logic                          pend_b,
  output logic                          pend_c,
  output logic [sb_pkg::UW-1:0]         own_b,
  output logic [sb_pkg::UW-1:0]         own_c
);
  import sb_pkg::*;

  logic [NREG-1:0] pend_q;
  logic [UW-1:0]   own_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NREG; i++) own_q[i] <= '0;
    end else if (clr) begin
      pend_q <= '0;
    end else begin
      for (int u = 0; u < NFU; u++)
        if (rel_en[u]) pend_q[rel_idx[u*RW +: RW]] <= 1'b0;
      if (set_en) begin
        pend_q[set_idx] <= 1'b1;
        own_q[set_idx]  <= set_unit;
      end
    end
  end

  assign pend_a = pend_q[look_a];
  assign pend_b = pend_q[look_b];
  assign pend_c = pend_q[look_c];
  assign own_b  = own_q[look_b];
  assign own_c  = own_q[look_c];

  AST_NO_DOUBLE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |-> !pend_q[set_idx]) else $error("second writer claimed register"); // R2
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot #(
  parameter int CW   = 16,
  parameter int TAGW = 4,
  parameter int LATW = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     adv,
  input  logic [CW-1:0]            cyc,
  input  logic                     iss_en,
  input  logic [sb_pkg::RW-1:0]    iss_fi,
  input  logic [sb_pkg::RW-1:0]    iss_fj,
  input  logic [sb_pkg::RW-1:0]    iss_fk,
  input  logic                     iss_fi_en,
  input  logic                     iss_fk_en,
  input  logic [sb_pkg::UW-1:0]    iss_qj,
  input  logic [sb_pkg::UW-1:0]    iss_qk,
  input  logic                     iss_rj,
  input  logic                     iss_rk,
  input  logic [TAGW-1:0]          iss_tag,
  input  logic [LATW-1:0]          iss_lat,
  input  logic [sb_pkg::NFU-1:0]   wr_bcast,
  input  logic                     war_block,
  output logic                     busy,
  output logic                     wr_fire,
  output logic [sb_pkg::RW-1:0]    fi,
  output logic                     fi_en,
  output logic [sb_pkg::RW-1:0]    fj,
  output logic [sb_pkg::RW-1:0]    fk,
  output logic                     watch_j,
  output logic                     watch_k,
  output logic [TAGW-1:0]          tag,
  output logic [CW-1:0]            iss_c,
  output logic [CW-1:0]            rd_c,
  output logic [CW-1:0]            ex_c
);
  import sb_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_EX, ST_WR} st_e;

  st_e             st;
  logic            fk_en, rj, rk;
  logic [UW-1:0]   qj, qk;
  logic [LATW-1:0] lat_q, cnt;
  logic            rd_fire;

  assign busy    = (st != ST_IDLE);
  assign rd_fire = adv && (st == ST_RD) && rj && rk;
  assign wr_fire = adv && (st == ST_WR) && !war_block;
  assign watch_j = (st == ST_RD) && rj;
  assign watch_k = (st == ST_RD) && fk_en && rk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; fi <= '0; fj <= '0; fk <= '0; fi_en <= 1'b0; fk_en <= 1'b0;
      qj <= '0; qk <= '0; rj <= 1'b0; rk <= 1'b0; tag <= '0; lat_q <= '0;
      cnt <= '0; iss_c <= '0; rd_c <= '0; ex_c <= '0;
    end else if (clr) begin
      st <= ST_IDLE;
    end else if (adv) begin
      case (st)
        ST_IDLE: if (iss_en) begin
          st <= ST_RD; fi <= iss_fi; fj <= iss_fj; fk <= iss_fk;
          fi_en <= iss_fi_en; fk_en <= iss_fk_en; qj <= iss_qj; qk <= iss_qk;
          rj <= iss_rj; rk <= iss_rk; tag <= iss_tag; lat_q <= iss_lat; iss_c <= cyc;
        end
        ST_RD: begin
          if (rd_fire) begin
            st <= ST_EX; rd_c <= cyc; cnt <= lat_q;
          end
          for (int w = 0; w < NFU; w++) begin
            if (wr_bcast[w] && !rj && qj == UW'(w)) rj <= 1'b1;
            if (wr_bcast[w] && !rk && qk == UW'(w)) rk <= 1'b1;
          end
        end
        ST_EX: begin
          if (cnt <= LATW'(1)) begin
            st <= ST_WR; ex_c <= cyc;
          end else begin
            cnt <= cnt - LATW'(1);
          end
        end
        default: if (!war_block) st <= ST_IDLE;
      endcase
    end
  end

  AST_ISSUE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_en && adv) |-> (st == ST_IDLE)) else $error("issue into busy unit"); // R1
  AST_READ_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (cyc > iss_c)) else $error("read in issue cycle"); // R3
  AST_EXEC_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && st == ST_EX && cnt <= LATW'(1)) |-> ((cyc - rd_c) == CW'(lat_q)))
    else $error("execution span wrong"); // R4
  AST_WRITE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (cyc > ex_c)) else $error("write in execute cycle"); // R5
endmodule

// File: rtl/sb_sched.sv
module sb_sched #(
  parameter int CW      = 16,
  parameter int TAGW    = 4,
  parameter int LATW    = 7,
  parameter int LAT_MAX = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_op,
  input  logic [5:0]            in_dst,
  input  logic [5:0]            in_src1,
  input  logic [5:0]            in_src2,
  input  logic                  in_last,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_sel,
  input  logic [LATW-1:0]       cfg_val,
  output logic [3:0]            rec_valid,
  input  logic                  rec_ready,
  output logic [4*TAGW-1:0]     rec_tag,
  output logic [4*CW-1:0]       rec_iss,
  output logic [4*CW-1:0]       rec_rd,
  output logic [4*CW-1:0]       rec_ex,
  output logic [4*CW-1:0]       rec_wr,
  output logic                  done
);
  import sb_pkg::*;

  logic              adv, issue, has_dst, k_en, started_q, last_q, lock;
  logic [UW-1:0]     unit, own_j, own_k;
  logic              pend_d, pend_j, pend_k, iss_rj, iss_rk;
  logic [CW-1:0]     cyc;
  logic [TAGW-1:0]   tag_q;
  logic [2:0]        lcls;
  logic [NCLS*LATW-1:0] lat_flat;
  logic [LATW-1:0]   iss_lat;
  logic [NFU-1:0]    busy, wr_fire, fi_en, watch_j, watch_k, war;
  logic [RW-1:0]     fi [NFU];
  logic [RW-1:0]     fj [NFU];
  logic [RW-1:0]     fk [NFU];
  logic [TAGW-1:0]   s_tag [NFU];
  logic [CW-1:0]     s_iss [NFU];
  logic [CW-1:0]     s_rd  [NFU];
  logic [CW-1:0]     s_ex  [NFU];
  logic [NFU*RW-1:0] rel_idx;

  assign adv     = rec_ready || (rec_valid == '0);
  assign unit    = unit_of(in_op);
  assign has_dst = (in_op != OP_SD);
  assign k_en    = (in_op != OP_LD);
  assign lcls    = lat_cls_of(in_op);
  assign iss_lat = lat_flat[lcls*LATW +: LATW];
  assign in_ready = adv && !clr && !busy[unit] && !(has_dst && pend_d);
  assign issue    = in_valid && in_ready;
  assign iss_rj   = !pend_j || wr_fire[own_j];
  assign iss_rk   = !k_en || !pend_k || wr_fire[own_k];
  assign done     = last_q && (busy == '0);
  assign lock     = started_q && !done;

  sb_lat_cfg #(.LATW(LATW), .LAT_MAX(LAT_MAX)) u_lat (
    .clk(clk), .rst_n(rst_n), .lock(lock), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .lat_flat(lat_flat));

  sb_regstat u_rstat (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .set_en(issue && has_dst), .set_idx(in_dst), .set_unit(unit),
    .rel_en(wr_fire & fi_en), .rel_idx(rel_idx),
    .look_a(in_dst), .look_b(in_src1), .look_c(in_src2),
    .pend_a(pend_d), .pend_b(pend_j), .pend_c(pend_k), .own_b(own_j), .own_c(own_k));

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war[u] = 1'b0;
      for (int v = 0; v < NFU; v++)
        if (v != u && fi_en[u] &&
            ((watch_j[v] && fj[v] == fi[u]) || (watch_k[v] && fk[v] == fi[u])))
          war[u] = 1'b1;
    end
  end

  for (genvar u = 0; u < NFU; u++) begin : g_fu
    logic           rv_q;
    logic [TAGW-1:0] rt_q;
    logic [CW-1:0]  ri_q, rr_q, re_q, rw_q;

    sb_fu_slot #(.CW(CW), .TAGW(TAGW), .LATW(LATW)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .cyc(cyc),
      .iss_en(issue && unit == UW'(u)), .iss_fi(in_dst), .iss_fj(in_src1),
      .iss_fk(in_src2), .iss_fi_en(has_dst), .iss_fk_en(k_en),
      .iss_qj(own_j), .iss_qk(own_k), .iss_rj(iss_rj), .iss_rk(iss_rk),
      .iss_tag(tag_q), .iss_lat(iss_lat), .wr_bcast(wr_fire), .war_block(war[u]),
      .busy(busy[u]), .wr_fire(wr_fire[u]), .fi(fi[u]), .fi_en(fi_en[u]),
      .fj(fj[u]), .fk(fk[u]), .watch_j(watch_j[u]), .watch_k(watch_k[u]),
      .tag(s_tag[u]), .iss_c(s_iss[u]), .rd_c(s_rd[u]), .ex_c(s_ex[u]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q <= 1'b0; rt_q <= '0; ri_q <= '0; rr_q <= '0; re_q <= '0; rw_q <= '0;
      end else if (clr) begin
        rv_q <= 1'b0;
      end else if (adv) begin
        rv_q <= wr_fire[u];
        if (wr_fire[u]) begin
          rt_q <= s_tag[u]; ri_q <= s_iss[u]; rr_q <= s_rd[u]; re_q <= s_ex[u]; rw_q <= cyc;
        end
      end
    end

    assign rel_idx[u*RW +: RW]   = fi[u];
    assign rec_valid[u]          = rv_q;
    assign rec_tag[u*TAGW +: TAGW] = rt_q;
    assign rec_iss[u*CW +: CW]   = ri_q;
    assign rec_rd[u*CW +: CW]    = rr_q;
    assign rec_ex[u*CW +: CW]    = re_q;
    assign rec_wr[u*CW +: CW]    = rw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= CW'(1); tag_q <= '0; started_q <= 1'b0; last_q <= 1'b0;
    end else if (clr) begin
      cyc <= CW'(1); tag_q <= '0; started_q <= 1'b0; last_q <= 1'b0;
    end else if (adv) begin
      cyc <= cyc + CW'(1);
      if (issue) begin
        tag_q     <= tag_q + TAGW'(1);
        started_q <= 1'b1;
        if (in_last) last_q <= 1'b1;
      end
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((rec_valid != '0) && !rec_ready && !clr) |=>
      ($stable(rec_valid) && $stable(rec_wr) && $stable(rec_tag)))
    else $error("record changed while stalled"); // R8
  AST_FROZEN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cyc)) else $error("cycle moved while frozen"); // R8
endmodule

// File: tb/sb_sched_bench.sv
module sb_sched_bench;
  localparam int CW = 16, TAGW = 4, LATW = 7;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, cfg_we = 1'b0, rec_ready = 1'b1;
  logic [2:0] in_op = '0, cfg_sel = '0;
  logic [5:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [LATW-1:0] cfg_val = '0;
  logic in_ready, done;
  logic [3:0] rec_valid;
  logic [4*TAGW-1:0] rec_tag;
  logic [4*CW-1:0] rec_iss, rec_rd, rec_ex, rec_wr;

  always #5 clk = ~clk;

  sb_sched #(.CW(CW), .TAGW(TAGW), .LATW(LATW)) u_sb_sched (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_last(in_last), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_tag(rec_tag),
    .rec_iss(rec_iss), .rec_rd(rec_rd), .rec_ex(rec_ex), .rec_wr(rec_wr), .done(done));

  typedef struct {int tag; int iss; int rd; int ex; int wr; string rq;} exp_t;
  exp_t expq[$];
  int total = 0, bad = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic push_exp(input int tag, input int iss, input int rd,
                          input int ex, input int wr, input string rq);
    exp_t e;
    e.tag = tag; e.iss = iss; e.rd = rd; e.ex = ex; e.wr = wr; e.rq = rq;
    expq.push_back(e);
  endtask

  // monitor: pops the matching expected item for every accepted record
  initial begin
    forever begin
      @(negedge clk); #2;
      for (int u = 0; u < 4; u++) begin
        if (rst_n && rec_valid[u] && rec_ready) begin
          int t, k;
          t = int'(rec_tag[u*TAGW +: TAGW]);
          k = -1;
          for (int i = 0; i < expq.size(); i++) if (expq[i].tag == t && k < 0) k = i;
          check(k >= 0, "R8", "record tag known", t, -1);
          if (k >= 0) begin
            check(int'(rec_iss[u*CW +: CW]) == expq[k].iss, "R1", "issue cycle",
                  int'(rec_iss[u*CW +: CW]), expq[k].iss);
            check(int'(rec_rd[u*CW +: CW]) == expq[k].rd, expq[k].rq, "read cycle",
                  int'(rec_rd[u*CW +: CW]), expq[k].rd);
            check(int'(rec_ex[u*CW +: CW]) == expq[k].ex, "R4", "exec cycle",
                  int'(rec_ex[u*CW +: CW]), expq[k].ex);
            check(int'(rec_wr[u*CW +: CW]) == expq[k].wr, "R5", "write cycle",
                  int'(rec_wr[u*CW +: CW]), expq[k].wr);
            expq.delete(k);
          end
        end
      end
    end
  end

  // driver: called at a negedge, returns at a negedge
  task automatic send(input int op, input int dst, input int s1, input int s2,
                      input bit last);
    in_op = 3'(op); in_dst = 6'(dst); in_src1 = 6'(s1); in_src2 = 6'(s2);
    in_last = last; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic cfg(input int sel, input int val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_val = LATW'(val);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic drain(input string rq);
    int n = 0;
    while (expq.size() != 0 && n < 400) begin @(negedge clk); #3; n++; end
    check(expq.size() == 0, rq, "records outstanding", expq.size(), 0);
  endtask

  function automatic int F(input int n); return 32 + n; endfunction

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9 reset state
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    check(rec_valid == 4'd0, "R9", "rec_valid after reset", rec_valid, 0);
    check(done == 1'b0, "R9", "done after reset", done, 0);

    // Run 1: default latencies; RAW, WAR, structural and out-of-order completion
    push_exp(0, 1, 2, 3, 4, "R3");
    push_exp(1, 5, 6, 7, 8, "R3");
    push_exp(2, 6, 9, 19, 20, "R3");
    push_exp(3, 7, 9, 11, 12, "R3");
    push_exp(4, 8, 21, 61, 62, "R3");
    push_exp(5, 13, 14, 16, 22, "R5");   // WAR hold behind the divide read
    do_clear();
    send(1, F(6), 2, 0, 0);
    send(1, F(2), 3, 0, 0);
    send(4, F(0), F(2), F(4), 0);
    send(3, F(8), F(6), F(2), 0);
    check(done == 1'b0, "R10", "done mid-run", done, 0);
    send(5, F(10), F(0), F(6), 0);
    send(3, F(6), F(8), F(2), 1);
    drain("R7");
    @(negedge clk); #2;
    check(done == 1'b1, "R10", "done after last write", done, 1);

    // Run 2: latency config, same-cycle issue/write, store and load operand rules
    cfg(1, 0);     // out of range, ignored
    cfg(3, 101);   // out of range, ignored
    cfg(3, 3);     // multiply latency 3
    push_exp(0, 1, 2, 5, 6, "R7");
    push_exp(1, 2, 3, 4, 5, "R7");
    push_exp(2, 6, 7, 8, 9, "R11");
    push_exp(3, 7, 8, 10, 11, "R6");
    push_exp(4, 10, 11, 12, 13, "R6");
    push_exp(5, 11, 12, 15, 16, "R7");
    do_clear();
    fork
      begin
        send(4, F(1), F(2), F(3), 0);
        send(0, 1, 2, 3, 0);
        send(2, F(9), 1, F(1), 0);
        send(3, F(9), F(2), F(3), 0);
        send(1, F(12), 7, F(9), 0);
        send(4, F(13), F(2), F(3), 1);
      end
      begin
        repeat (3) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_val = LATW'(9);  // R7 locked while active
        @(negedge clk); cfg_we = 1'b0;
      end
    join
    drain("R6");

    // Run 3: WAW stall and record back-pressure freeze
    push_exp(0, 1, 2, 4, 5, "R3");
    push_exp(1, 6, 7, 10, 11, "R2");
    push_exp(2, 7, 8, 9, 10, "R8");
    do_clear();
    rec_ready = 1'b0;
    fork
      begin
        send(3, F(1), F(2), F(3), 0);
        send(4, F(1), F(4), F(5), 0);
        send(0, 1, 2, 3, 1);
      end
      begin
        while (rec_valid == 4'd0) @(negedge clk);
        repeat (3) begin
          @(negedge clk); #2;
          check(in_ready == 1'b0, "R8", "in_ready frozen", in_ready, 0);
          check(rec_valid == 4'b0010, "R8", "record held on lane 1", rec_valid, 2);
        end
        @(negedge clk);
        rec_ready = 1'b1;
      end
    join
    drain("R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule